// File: doc/BRIEF.md
# Flash Word Programming Sequencer

This block sits on the host side of a parallel NOR flash bus and writes a run of consecutive words into the device. A single start pulse supplies the first word address and the number of words. For each word the block pulls the word's value from a one-cycle request interface. It then writes the three unlock/program command cycles and the data cycle, and watches the device's status bits until the word is confirmed or declared failed.

Completion is judged by the data-polling rule. The block reads the target address and compares bit 7 of the read with bit 7 of the value written. If they differ while the device's time-limit flag (bit 5) is set, the block reads once more. Bit 7 can settle in the same instant as bit 5 rises, so only that second read decides between pass and fail. A device that never raises bit 5 is caught by a bounded count of poll reads. On any failure the block writes the return-to-read command and stops with an error flag. After the final word it stops with a done flag.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset the bus is idle: `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, `fl_dq_oe` is 0, and `data_req`, `done` and `error` are 0.
- R2: `start` is taken only while idle. Taking it clears `done` and `error`. For each word, `data_req` is high for exactly one cycle with the bus idle, and `data_in` is captured in that cycle.
- R3: Each word is written as four bus writes, in this order: 0x00AA at 0x555, 0x0055 at 0x2AA, 0x00A0 at 0x555, then the word at its target address. Each write lasts two cycles, the first with `fl_we_n`=0 and the second with `fl_we_n`=1. Address and data are held across both cycles, with `fl_ce_n`=0, `fl_oe_n`=1 and `fl_dq_oe`=1.
- R4: The write cycles are followed by single-cycle poll reads at the target address, with `fl_ce_n`=0, `fl_oe_n`=0, `fl_we_n`=1 and `fl_dq_oe`=0. If bit 7 of the read equals bit 7 of the written word, the word passes.
- R5: If bit 7 differs and bit 5 of the read is 1, exactly one more read follows at the same address. A bit 7 match on that read passes the word; otherwise the word fails.
- R6: If bit 7 differs and bit 5 is 0, polling continues. After `POLL_LIMIT` such reads of one word without a decision, the word fails.
- R7: A passed word is followed by the next word at address+1 (wrapping at the address width). After `word_count` words pass, the block returns to idle with `done`=1, and `done` stays at 1 until the next accepted start.
- R8: On a failed word the block writes 0x00F0 at that word's address, as one two-cycle write. It then idles with `error`=1 and `done`=0, both held until the next accepted start, and no later word is attempted.
- R9: A start with `word_count`=0 produces no bus access and shows `done`=1 in the next cycle.
- R10: A `start` pulse while a run is in progress has no effect on the bus sequence or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run (sampled while idle) |
| start_addr | input | AW | First word address |
| word_count | input | CW | Number of words to program |
| data_req | output | 1 | One-cycle request for the next word's value |
| data_in | input | DW | Word value, valid in the `data_req` cycle |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Data driven to the flash |
| fl_dq_oe | output | 1 | Host drives the data bus when 1 |
| fl_dq_in | input | DW | Data read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| done | output | 1 | All words programmed |
| error | output | 1 | Run aborted on a failed word |

## Verification
A wrong state or step index shows within one cycle as a wrong command value, address or strobe level on the bus, because every bus cycle of a run is predicted. A wrong poll decision shows in the cycle after the deciding read: an extra or missing read, an early reset command, or a fetch of the next word. A stale word address or count shows no later than the next data cycle or the final flag. The flash stand-in covers four kinds of word: a quick pass, a pass on the re-read after bit 5 rises, a hard failure, and a device that never answers.

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_count,
  output logic          data_req,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          done,
  output logic          error
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [AW-1:0] UNLK_A = AW'(12'h555);
  localparam logic [AW-1:0] UNLK_B = AW'(12'h2AA);

  typedef enum logic [2:0] {IDLE, FETCH, WRITE, POLL, RECHK, ABORT} st_t;

  st_t           st;
  logic [1:0]    step;
  logic          ph;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;
  logic [DW-1:0] data_q;
  logic [PW-1:0] pc;
  logic          done_q, err_q;

  wire writing = (st == WRITE) || (st == ABORT);
  wire reading = (st == POLL) || (st == RECHK);
  wire hit     = fl_dq_in[7] == data_q[7];
  wire last    = left_q == CW'(1);

  assign data_req = st == FETCH;
  assign fl_ce_n  = !(writing || reading);
  assign fl_we_n  = !(writing && !ph);
  assign fl_oe_n  = !reading;
  assign fl_dq_oe = writing;
  assign done     = done_q;
  assign error    = err_q;

  always_comb begin
    fl_addr   = addr_q;
    fl_dq_out = data_q;
    if (st == ABORT) fl_dq_out = DW'(8'hF0);
    else if (st == WRITE) begin
      case (step)
        2'd0: begin fl_addr = UNLK_A; fl_dq_out = DW'(8'hAA); end
        2'd1: begin fl_addr = UNLK_B; fl_dq_out = DW'(8'h55); end
        2'd2: begin fl_addr = UNLK_A; fl_dq_out = DW'(8'hA0); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      step   <= '0;
      ph     <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      data_q <= '0;
      pc     <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          done_q <= word_count == '0;
          err_q  <= 1'b0;
          addr_q <= start_addr;
          left_q <= word_count;
          if (word_count != '0) st <= FETCH;
        end
        FETCH: begin
          data_q <= data_in;
          step   <= '0;
          ph     <= 1'b0;
          st     <= WRITE;
        end
        WRITE: begin
          ph <= !ph;
          if (ph) begin
            if (step == 2'd3) begin
              st <= POLL;
              pc <= '0;
            end else step <= step + 2'd1;
          end
        end
        POLL, RECHK: begin
          if (hit) begin
            if (last) begin
              st     <= IDLE;
              done_q <= 1'b1;
            end else begin
              st     <= FETCH;
              addr_q <= addr_q + AW'(1);
              left_q <= left_q - CW'(1);
            end
          end else if (st == POLL && fl_dq_in[5]) begin
            st <= RECHK;
          end else if (st == RECHK || pc == PW'(POLL_LIMIT - 1)) begin
            st <= ABORT;
            ph <= 1'b0;
          end else begin
            pc <= pc + PW'(1);
          end
        end
        ABORT: begin
          ph <= 1'b1;
          if (ph) begin
            st    <= IDLE;
            err_q <= 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          data_req,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out,
  input logic          fl_dq_oe,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic          done,
  input logic          error
);
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) !fl_we_n |-> !fl_ce_n); // R3
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |=> fl_we_n && !fl_ce_n && fl_dq_oe && $stable(fl_addr) && $stable(fl_dq_out)); // R3
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n) fl_dq_oe |-> fl_oe_n); // R4
  AST_READ_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !fl_oe_n |-> fl_we_n && !fl_ce_n); // R4
  AST_FETCH_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) data_req |-> fl_ce_n); // R2
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) data_req |=> !data_req); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R8
  AST_FLAG_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n) (done || error) |-> fl_ce_n); // R7
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_req(data_req), .fl_addr(fl_addr),
  .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n),
  .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .done(done), .error(error)
);

// File: tb/flash_prog_ctrl_bench.sv
`timescale 1ns/1ps
module flash_prog_ctrl_bench;
  localparam int AW = 18, DW = 16, CW = 16, LIM = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic [DW-1:0] data_in, fl_dq_in, fl_dq_out;
  logic [AW-1:0] fl_addr;
  logic data_req, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, done, error;

  always #4 clk = ~clk;

  flash_prog_ctrl #(.AW(AW), .DW(DW), .CW(CW), .POLL_LIMIT(LIM)) u_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .data_req(data_req), .data_in(data_in),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .done(done), .error(error));

  int compared = 0, mismatched = 0, cyc = 0;
  logic [DW-1:0] words [4];
  int req_n = 0, req_base = 0;
  int wc = 0, wc_base = 0, rc = 0, bad_idx = -1, bad_mode = 0;
  logic [DW-1:0] lw = '0;

  assign data_in = words[(req_n - req_base) & 3];
  always @(posedge clk) if (data_req) req_n <= req_n + 1;

  always @(posedge clk) begin
    if (!fl_ce_n && !fl_we_n) begin
      wc <= wc + 1; rc <= 0; lw <= fl_dq_out;
    end else if (!fl_ce_n && !fl_oe_n) rc <= rc + 1;
  end

  always_comb begin
    int k, m;
    logic busy, f5;
    k = (wc - wc_base) / 4 - 1;
    m = (k == bad_idx) ? bad_mode : 0;
    busy = 1'b0; f5 = 1'b0;
    case (m)
      1: begin busy = rc < 3; f5 = rc == 2; end
      2: begin busy = 1'b1; f5 = rc >= 1; end
      3: busy = 1'b1;
      default: busy = rc < 2;
    endcase
    fl_dq_in = lw;
    if (busy) begin
      fl_dq_in = '0;
      fl_dq_in[7] = ~lw[7];
      fl_dq_in[6] = rc[0];
      fl_dq_in[5] = f5;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic rq, input logic ce, input logic we,
                     input logic oe, input logic drv, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic dn, input logic er);
    logic bad;
    @(negedge clk);
    start = 1'b0;
    compared = compared + 1;
    bad = {data_req, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, done, error} !== {rq, ce, we, oe, drv, dn, er};
    if (!ce && fl_addr !== a) bad = 1'b1;
    if (drv && fl_dq_out !== d) bad = 1'b1;
    if (bad) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual req/ce/we/oe/drv/done/err=%b%b%b%b%b%b%b addr=%h dq=%h expected %b%b%b%b%b%b%b addr=%h dq=%h",
               tag, data_req, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, done, error, fl_addr, fl_dq_out,
               rq, ce, we, oe, drv, dn, er, a, d);
    end
  endtask

  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk(tag, 0, 0, 0, 1, 1, a, d, 0, 0);
    chk(tag, 0, 0, 1, 1, 1, a, d, 0, 0);
  endtask

  task automatic run(input logic [AW-1:0] sa, input int n, input int bad, input int bmode, input bit poke);
    logic ok;
    @(negedge clk);
    wc_base = wc; req_base = req_n; bad_idx = bad; bad_mode = bmode;
    start = 1'b1; start_addr = sa; word_count = CW'(n);
    if (n == 0) begin
      chk("R9 empty run", 0, 1, 1, 1, 0, '0, '0, 1, 0);
      return;
    end
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ta;
      int polls;
      bit fin;
      ta = sa + AW'(i);
      chk("R2 fetch", 1, 1, 1, 1, 0, '0, '0, 0, 0);
      wr("R3 unlock1", AW'(12'h555), 16'h00AA);
      if (poke && i == 0) begin
        start = 1'b1; start_addr = '1; word_count = CW'(1);
      end
      wr("R3 unlock2", AW'(12'h2AA), 16'h0055);
      wr("R3 setup", AW'(12'h555), 16'h00A0);
      wr(poke ? "R10 data" : "R3 data", ta, words[i]);
      polls = 0; fin = 0; ok = 0;
      while (!fin) begin
        chk("R4 poll read", 0, 0, 1, 0, 0, ta, '0, 0, 0);
        polls++;
        if (fl_dq_in[7] == words[i][7]) begin ok = 1; fin = 1; end
        else if (fl_dq_in[5]) begin
          chk("R5 re-read", 0, 0, 1, 0, 0, ta, '0, 0, 0);
          ok = fl_dq_in[7] == words[i][7];
          fin = 1;
        end else if (polls == LIM) fin = 1;
      end
      if (!ok) begin
        wr((bmode == 3) ? "R6 abort" : "R8 abort", ta, 16'h00F0);
        chk("R8 error", 0, 1, 1, 1, 0, '0, '0, 0, 1);
        chk("R8 error held", 0, 1, 1, 1, 0, '0, '0, 0, 1);
        return;
      end
    end
    chk("R7 done", 0, 1, 1, 1, 0, '0, '0, 1, 0);
    chk("R7 done held", 0, 1, 1, 1, 0, '0, '0, 1, 0);
  endtask

  initial begin
    words[0] = 16'h1234; words[1] = 16'h00FF; words[2] = 16'hBE80; words[3] = 16'h0001;
    repeat (3) @(posedge clk);
    chk("R1 reset idle", 0, 1, 1, 1, 0, '0, '0, 0, 0);
    @(negedge clk) rst_n = 1'b1;
    chk("R1 idle after reset", 0, 1, 1, 1, 0, '0, '0, 0, 0);
    run(18'h00100, 3, -1, 0, 1);
    words[0] = 16'h8000; words[1] = 16'h7F7F;
    run(18'h3FFFF, 2, 1, 1, 0);
    words[0] = 16'h0011; words[1] = 16'h8888; words[2] = 16'h4444;
    run(18'h00555, 3, 1, 2, 0);
    run(18'h00020, 2, 0, 3, 0);
    run(18'h00000, 0, -1, 0, 0);
    words[0] = 16'hFFFF;
    run(18'h12345, 1, -1, 0, 0);
    summary();
    $finish;
  end
endmodule